// File: doc/BRIEF.md
# EDO DRAM Controller with Refresh

This block sits between a simple CPU-side request port and up to four non-interleaved banks of EDO DRAM on a 32-bit data bus. It accepts a single-word or four-word burst read or write. It then produces the strobe sequence for that access: a per-bank row strobe, a per-byte-lane column strobe, a shared write enable and a row/column multiplexed address. Reads are controlled by the column strobe and writes are early writes, so the output-enable pins of the DRAM chips can be tied low. The block also drives the enable and direction of an external data transceiver.

Refresh runs without any CPU involvement. An internal interval counter raises a refresh request, and the sequencer serves it with a column-before-row refresh of all banks as soon as it is idle. A refresh goes ahead of a request that is waiting, but it never interrupts an access that is in progress. An active-low wait input freezes the sequence at any point for as long as it is held.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The request word address splits, from the LSB upward, into column (COL_W bits), row (ROW_W bits) and bank. During an access, only the row strobe of the addressed bank is low (bit b of `dram_ras_no` belongs to bank b).
- R2: During a write word, the column strobe goes low only on lanes whose `req_be_i` bit is 1 (bit i is byte lane i). During a read word, all four lane strobes go low.
- R3: Write enable goes low in the first cycle of a write access and stays low until the access ends, so it is always low before any column strobe falls. It is high during reads, refresh and idle.
- R4: An access runs as follows. First one cycle with the row address and all strobes high. Then RCD cycles with the bank row strobe low and the row address still shown. Then, for each word, one cycle showing the column address with the column strobes high, followed by one cycle with the column strobes low and `xfer_o` high. Last come TRP cycles with every strobe high.
- R5: A burst (`req_burst_i`=1) moves four words. In linear order (`req_subblk_i`=0) the two low column bits of word k are (start + k) mod 4.
- R6: In sub-block order (`req_subblk_i`=1) the two low column bits of word k are start XOR k. The upper column bits stay fixed.
- R7: Every REF_INT clocks a refresh request is raised internally. It is served as one cycle with all column strobes low and all row strobes high, then RFW cycles with all strobes low, then TRP cycles with all strobes high.
- R8: Write enable stays high throughout every refresh.
- R9: A pending refresh starts before a request that is waiting. An access already under way finishes first. While a refresh is pending, `req_ready_o` is low.
- R10: While `wait_ni` is low the sequence does not advance: strobes, address and enables keep their values, `xfer_o` is low and no request is accepted.
- R11: `xcvr_oe_no` is low and `xcvr_dir_o` equals the write flag from the row cycle through the last column-strobe cycle of every read and write access. Otherwise they are high and low respectively.
- R12: `req_ready_o` is high only when the controller is idle, no refresh is pending and `wait_ni` is high. A request is taken on a clock where `req_valid_i` and `req_ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this clock if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | 1 = four-word burst, 0 = single word |
| req_subblk_i | input | 1 | Burst order: 1 = sub-block, 0 = linear |
| req_addr_i | input | BANK_W+ROW_W+COL_W | Word address {bank, row, column} |
| req_be_i | input | 4 | Byte-lane enables for writes |
| wait_ni | input | 1 | Wait request, active low; freezes the sequence |
| dram_addr_o | output | MA_W | Multiplexed row/column address |
| dram_ras_no | output | BANKS | Row strobes, one per bank, active low |
| dram_cas_no | output | 4 | Column strobes, one per byte lane, active low |
| dram_we_no | output | 1 | Shared write enable, active low |
| xcvr_oe_no | output | 1 | Data transceiver enable, active low |
| xcvr_dir_o | output | 1 | Transceiver direction, 1 = toward DRAM |
| xfer_o | output | 1 | A data word completes on this clock |

## Verification
A refresh interval can expire in the same cycle that a request is presented or that an access is still running. That makes the refresh scheduler and the access sequencer compete for the idle slot. The bench provokes this by streaming back-to-back burst and single requests across many refresh intervals, and it also pulls the wait input low both in the middle of a burst and while idle with a request held. A queue-based reference model builds the expected strobe frames for each accepted access or refresh, advances them only on unstalled clocks, and is compared with every output on every clock. Refresh starts are also counted against the number of intervals that have elapsed.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_RCD, ST_COL, ST_CAS, ST_PRE, ST_CBR, ST_RFSH
  } edo_st_e;
endpackage

// File: rtl/edo_ref_timer.sv
`timescale 1ns/1ps
module edo_ref_timer #(
  parameter int unsigned REF_INT = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(REF_INT + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(REF_INT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/edo_col_gen.sv
`timescale 1ns/1ps
module edo_col_gen #(
  parameter int unsigned COL_W = 10,
  parameter int unsigned BW    = 2
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [BW-1:0]    beat_i,
  input  logic             subblk_i,
  output logic [COL_W-1:0] col_o
);
  logic [BW-1:0] lo_lin, lo_sub;

  assign lo_lin = base_i[BW-1:0] + beat_i;  // wraps within the block
  assign lo_sub = base_i[BW-1:0] ^ beat_i;

  generate
    if (COL_W > BW) begin : g_hi
      assign col_o = {base_i[COL_W-1:BW], (subblk_i ? lo_sub : lo_lin)};
    end else begin : g_lo
      assign col_o = subblk_i ? lo_sub : lo_lin;
    end
  endgenerate
endmodule

// File: rtl/edo_seq.sv
`timescale 1ns/1ps
module edo_seq
  import edo_pkg::*;
#(
  parameter int unsigned RCD       = 2,
  parameter int unsigned TRP       = 2,
  parameter int unsigned RFW       = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned BW        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wait_ni,
  input  logic          ref_tick_i,
  input  logic          go_i,
  input  logic          burst_i,
  output edo_st_e       st_o,
  output logic [BW-1:0] beat_o,
  output logic          ready_o
);
  localparam int unsigned TMAX = (RCD > TRP) ? ((RCD > RFW) ? RCD : RFW)
                                             : ((TRP > RFW) ? TRP : RFW);
  localparam int unsigned CW = $clog2(TMAX + 1);

  edo_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] beat_q, beat_d, last_q, last_d;
  logic          pend_q, pend_d;

  assign st_o    = st_q;
  assign beat_o  = beat_q;
  assign ready_o = (st_q == ST_IDLE) && !pend_q && wait_ni;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    beat_d = beat_q;
    last_d = last_q;
    pend_d = pend_q;
    if (wait_ni) begin
      unique case (st_q)
        ST_IDLE: begin
          if (pend_q) begin
            st_d   = ST_CBR;
            pend_d = 1'b0;
          end else if (go_i) begin
            st_d   = ST_ROW;
            beat_d = '0;
            last_d = burst_i ? BW'(BURST_LEN - 1) : '0;
          end
        end
        ST_ROW: begin
          st_d  = ST_RCD;
          cnt_d = '0;
        end
        ST_RCD: begin
          if (cnt_q == CW'(RCD - 1)) st_d = ST_COL;
          else                        cnt_d = cnt_q + 1'b1;
        end
        ST_COL: st_d = ST_CAS;
        ST_CAS: begin
          if (beat_q == last_q) begin
            st_d  = ST_PRE;
            cnt_d = '0;
          end else begin
            st_d   = ST_COL;
            beat_d = beat_q + 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt_q == CW'(TRP - 1)) st_d = ST_IDLE;
          else                        cnt_d = cnt_q + 1'b1;
        end
        ST_CBR: begin
          st_d  = ST_RFSH;
          cnt_d = '0;
        end
        ST_RFSH: begin
          if (cnt_q == CW'(RFW - 1)) begin
            st_d  = ST_PRE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (ref_tick_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      last_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      last_q <= last_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned BANKS     = 4,
  parameter int unsigned ROW_W     = 11,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned RCD       = 2,
  parameter int unsigned TRP       = 2,
  parameter int unsigned RFW       = 2,
  parameter int unsigned REF_INT   = 780,
  localparam int unsigned LANES    = 4,
  localparam int unsigned BANK_W   = $clog2(BANKS),
  localparam int unsigned ADDR_W   = BANK_W + ROW_W + COL_W,
  localparam int unsigned MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int unsigned BW       = $clog2(BURST_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_burst_i,
  input  logic              req_subblk_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]  req_be_i,
  input  logic              wait_ni,
  output logic [MA_W-1:0]   dram_addr_o,
  output logic [BANKS-1:0]  dram_ras_no,
  output logic [LANES-1:0]  dram_cas_no,
  output logic              dram_we_no,
  output logic              xcvr_oe_no,
  output logic              xcvr_dir_o,
  output logic              xfer_o
);
  edo_st_e           st;
  logic [BW-1:0]     beat;
  logic              ref_tick, go;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  colb_q, col;
  logic              wr_q, sub_q;
  logic [LANES-1:0]  be_q;
  logic              in_acc, row_ph, col_ph, bank_on, rfsh_cas;

  assign go = req_valid_i && req_ready_o;

  edo_ref_timer #(.REF_INT(REF_INT)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (ref_tick)
  );

  edo_seq #(
    .RCD(RCD), .TRP(TRP), .RFW(RFW), .BURST_LEN(BURST_LEN), .BW(BW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_ni    (wait_ni),
    .ref_tick_i (ref_tick),
    .go_i       (go),
    .burst_i    (req_burst_i),
    .st_o       (st),
    .beat_o     (beat),
    .ready_o    (req_ready_o)
  );

  edo_col_gen #(.COL_W(COL_W), .BW(BW)) u_col (
    .base_i   (colb_q),
    .beat_i   (beat),
    .subblk_i (sub_q),
    .col_o    (col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      row_q  <= '0;
      colb_q <= '0;
      wr_q   <= 1'b0;
      sub_q  <= 1'b0;
      be_q   <= '0;
    end else if (go) begin
      colb_q <= req_addr_i[COL_W-1:0];
      row_q  <= req_addr_i[COL_W +: ROW_W];
      bank_q <= req_addr_i[ADDR_W-1 -: BANK_W];
      wr_q   <= req_write_i;
      sub_q  <= req_subblk_i;
      be_q   <= req_be_i;
    end
  end

  assign row_ph   = (st == ST_ROW) || (st == ST_RCD);
  assign col_ph   = (st == ST_COL) || (st == ST_CAS);
  assign in_acc   = row_ph || col_ph;
  assign bank_on  = (st == ST_RCD) || col_ph;
  assign rfsh_cas = (st == ST_CBR) || (st == ST_RFSH);

  assign dram_we_no  = !(in_acc && wr_q);
  assign xcvr_oe_no  = !in_acc;
  assign xcvr_dir_o  = in_acc && wr_q;
  assign xfer_o      = (st == ST_CAS) && wait_ni;

  always_comb begin
    dram_addr_o = '0;
    if (row_ph)      dram_addr_o = MA_W'(row_q);
    else if (col_ph) dram_addr_o = MA_W'(col);
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_ras
    assign dram_ras_no[b] = !((bank_on && bank_q == BANK_W'(b)) || st == ST_RFSH);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cas
    assign dram_cas_no[l] = !(((st == ST_CAS) && (!wr_q || be_q[l])) || rfsh_cas);
  end
endmodule

// File: rtl/edo_dram_chk.sv
`timescale 1ns/1ps
module edo_dram_chk #(
  parameter int unsigned BANKS = 4,
  parameter int unsigned LANES = 4,
  parameter int unsigned MA_W  = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wait_ni,
  input logic             req_ready_o,
  input logic [MA_W-1:0]  dram_addr_o,
  input logic [BANKS-1:0] dram_ras_no,
  input logic [LANES-1:0] dram_cas_no,
  input logic             dram_we_no,
  input logic             xcvr_oe_no
);
  // R1
  one_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~dram_ras_no) <= 1) || (dram_ras_no == '0));

  // R3
  early_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_we_no && (dram_cas_no != '1) && ($past(dram_cas_no) == '1))
      |-> $past(!dram_we_no));

  // R8
  rfsh_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_ras_no == '0) |-> dram_we_no);

  // R10
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_ni |=> ($stable(dram_ras_no) && $stable(dram_cas_no) &&
                  $stable(dram_addr_o) && $stable(dram_we_no)));

  // R11
  xcvr_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($countones(~dram_ras_no) == 1) && (dram_cas_no != '1)) |-> !xcvr_oe_no);

  // R12
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> ((dram_ras_no == '1) && (dram_cas_no == '1)));
endmodule

bind edo_dram_ctrl edo_dram_chk #(.BANKS(BANKS), .LANES(LANES), .MA_W(MA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wait_ni     (wait_ni),
  .req_ready_o (req_ready_o),
  .dram_addr_o (dram_addr_o),
  .dram_ras_no (dram_ras_no),
  .dram_cas_no (dram_cas_no),
  .dram_we_no  (dram_we_no),
  .xcvr_oe_no  (xcvr_oe_no)
);

// File: tb/sim_edo_dram_ctrl.sv
`timescale 1ns/1ps
module sim_edo_dram_ctrl;
  localparam int RW = 11, CW = 10, RCD = 2, TRP = 2, RFW = 2, RI = 90;
  localparam int ADDR_W = 2 + RW + CW;
  localparam int MA_W = 11;

  typedef struct packed {
    logic [3:0]      ras;
    logic [3:0]      cas;
    logic            we;
    logic            oe;
    logic            dir;
    logic            xb;
    logic [MA_W-1:0] addr;
  } frm_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_burst = 0, req_sub = 0, wait_n = 1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic req_ready, dram_we_n, oe_n, dir, xfer;
  logic [MA_W-1:0] dram_addr;
  logic [3:0] ras_n, cas_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  frm_t q[$];
  bit m_pend = 0;
  int m_tcnt = 0;
  logic [1:0] obs_lo[$];
  logic [3:0] obs_cas[$];
  int n_ref = 0, n_acc = 0, we_bad = 0;
  logic [3:0] prev_ras = 4'hF, prev_cas = 4'hF;

  always #2.5 clk = ~clk;

  edo_dram_ctrl #(.BANKS(4), .ROW_W(RW), .COL_W(CW), .BURST_LEN(4),
                  .RCD(RCD), .TRP(TRP), .RFW(RFW), .REF_INT(RI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_burst_i(req_burst), .req_subblk_i(req_sub),
    .req_addr_i(req_addr), .req_be_i(req_be), .wait_ni(wait_n),
    .dram_addr_o(dram_addr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(dram_we_n), .xcvr_oe_no(oe_n), .xcvr_dir_o(dir), .xfer_o(xfer));

  function automatic frm_t idle_f();
    frm_t f;
    f.ras = 4'hF; f.cas = 4'hF; f.we = 1; f.oe = 1; f.dir = 0; f.xb = 0; f.addr = '0;
    return f;
  endfunction

  function automatic void push_access(logic w, logic [ADDR_W-1:0] a, logic [3:0] be,
                                      logic burst, logic sub);
    frm_t f;
    int bank = int'(a[ADDR_W-1 -: 2]);
    logic [RW-1:0] row = a[CW +: RW];
    logic [CW-1:0] col = a[CW-1:0];
    int n = burst ? 4 : 1;
    f = idle_f();
    f.we = ~w; f.oe = 0; f.dir = w; f.addr = MA_W'(row);
    q.push_back(f);
    f.ras = ~(4'b0001 << bank);
    for (int i = 0; i < RCD; i++) q.push_back(f);
    for (int k = 0; k < n; k++) begin
      logic [1:0] lo;
      lo = sub ? (col[1:0] ^ 2'(k)) : (col[1:0] + 2'(k));
      f.addr = MA_W'({col[CW-1:2], lo});
      f.cas = 4'hF; f.xb = 0; q.push_back(f);
      f.cas = w ? ~be : 4'h0; f.xb = 1; q.push_back(f);
    end
    for (int i = 0; i < TRP; i++) q.push_back(idle_f());
  endfunction

  function automatic void push_refresh();
    frm_t f;
    f = idle_f();
    f.cas = 4'h0; q.push_back(f);
    f.ras = 4'h0;
    for (int i = 0; i < RFW; i++) q.push_back(f);
    for (int i = 0; i < TRP; i++) q.push_back(idle_f());
  endfunction

  // reference model: frame queue advanced on unstalled clocks
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_pend = 0; m_tcnt = 0;
    end else begin
      if (q.size() != 0) begin
        if (wait_n) void'(q.pop_front());
      end else if (wait_n) begin
        if (m_pend) begin
          push_refresh(); m_pend = 0;
        end else if (req_valid) begin
          push_access(req_write, req_addr, req_be, req_burst, req_sub);
        end
      end
      if (m_tcnt == RI - 1) begin m_pend = 1; m_tcnt = 0; end
      else m_tcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle compare and monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      frm_t e;
      e = (q.size() != 0) ? q[0] : idle_f();
      chk("R1 R4 ras", 32'(ras_n), 32'(e.ras));
      chk("R2 R7 cas", 32'(cas_n), 32'(e.cas));
      chk("R3 R8 we", 32'(dram_we_n), 32'(e.we));
      chk("R4 R5 R6 addr", 32'(dram_addr), 32'(e.addr));
      chk("R11 oe", 32'(oe_n), 32'(e.oe));
      chk("R11 dir", 32'(dir), 32'(e.dir));
      chk("R4 R10 xfer", 32'(xfer), 32'(e.xb && wait_n));
      chk("R9 R12 ready", 32'(req_ready), 32'(q.size() == 0 && !m_pend && wait_n));
      if (xfer) begin
        obs_lo.push_back(dram_addr[1:0]);
        obs_cas.push_back(cas_n);
      end
      if (cas_n == 4'h0 && ras_n == 4'hF && prev_cas == 4'hF) n_ref++;
      if (ras_n != 4'hF && ras_n != 4'h0 && prev_ras == 4'hF) n_acc++;
      if (ras_n == 4'h0 && !dram_we_n) we_bad++;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  function automatic logic [ADDR_W-1:0] mk(int bank, int row, int col);
    return {2'(bank), RW'(row), CW'(col)};
  endfunction

  task automatic issue(logic w, logic [ADDR_W-1:0] a, logic [3:0] be, logic burst, logic sub);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_be = be; req_burst = burst; req_sub = sub;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    int base_ref, base_acc, t0;
    logic [3:0] s_ras, s_cas;
    logic [MA_W-1:0] s_addr;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset ras", 32'(ras_n), 32'hF);
    chk("R2 reset cas", 32'(cas_n), 32'hF);
    chk("R3 reset we", 32'(dram_we_n), 32'h1);
    chk("R11 reset oe", 32'(oe_n), 32'h1);
    chk("R12 reset ready", 32'(req_ready), 32'h1);
    @(posedge clk); #1 rst_n = 1;

    // single write, partial lanes
    obs_cas.delete();
    issue(1, mk(1, 12, 37), 4'b0101, 0, 0);
    drain();
    chk("R2 write lanes", 32'(obs_cas.size() ? obs_cas[0] : 4'hF), 32'hA);

    // single read
    obs_cas.delete();
    issue(0, mk(2, 300, 5), 4'b0011, 0, 0);
    drain();
    chk("R2 read lanes", 32'(obs_cas.size() ? obs_cas[0] : 4'hF), 32'h0);

    // linear burst from word 2
    obs_lo.delete();
    issue(1, mk(0, 7, 10'h1F6), 4'hF, 1, 0);
    drain();
    chk("R5 beats", 32'(obs_lo.size()), 32'd4);
    if (obs_lo.size() == 4)
      chk("R5 linear order", {24'h0, obs_lo[0], obs_lo[1], obs_lo[2], obs_lo[3]}, 32'b10110001);

    // sub-block burst from word 1
    obs_lo.delete();
    issue(0, mk(3, 99, 10'h0C5), 4'hF, 1, 1);
    drain();
    chk("R6 beats", 32'(obs_lo.size()), 32'd4);
    if (obs_lo.size() == 4)
      chk("R6 subblock order", {24'h0, obs_lo[0], obs_lo[1], obs_lo[2], obs_lo[3]}, 32'b01001110);

    // wait stall mid-burst
    issue(1, mk(1, 55, 10'h102), 4'b1100, 1, 1);
    repeat (4) @(posedge clk);
    #1 wait_n = 0;
    @(negedge clk);
    s_ras = ras_n; s_cas = cas_n; s_addr = dram_addr;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 hold ras", 32'(ras_n), 32'(s_ras));
      chk("R10 hold cas", 32'(cas_n), 32'(s_cas));
      chk("R10 hold addr", 32'(dram_addr), 32'(s_addr));
      chk("R10 no xfer", 32'(xfer), 32'h0);
    end
    @(posedge clk); #1 wait_n = 1;
    drain();

    // wait while idle with a request held
    base_acc = n_acc;
    #0 wait_n = 0; req_valid = 1; req_write = 0; req_burst = 0; req_sub = 0;
    req_addr = mk(2, 1, 1); req_be = 4'hF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 R12 ready low", 32'(req_ready), 32'h0);
    end
    chk("R10 no accept", 32'(n_acc - base_acc), 32'h0);
    @(posedge clk); #1 wait_n = 1; req_valid = 0;
    drain();

    // idle refresh cadence
    base_ref = n_ref;
    repeat (3 * RI) @(posedge clk);
    chk("R7 refresh count", 32'((n_ref - base_ref) >= 2 && (n_ref - base_ref) <= 4), 32'h1);

    // streaming requests across many refresh intervals
    base_ref = n_ref;
    t0 = 0;
    for (int i = 0; i < 60; i++) begin
      issue(i[0], mk(i % 4, i * 3, i * 5), 4'(i + 1), i[1], i[2]);
      t0++;
    end
    drain();
    chk("R9 refresh not starved", 32'((n_ref - base_ref) >= 4), 32'h1);
    chk("R8 we high in refresh", 32'(we_bad), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule